// File: doc/BRIEF.md
# Signed/Unsigned 8x8 Single-Cycle Array Multiplier

This block multiplies two 8-bit operands and returns the full 16-bit product one clock after the operands are presented. A mode input chooses how the operands are read for each transaction. With mode 0 they are unsigned numbers. With mode 1 they are two's-complement numbers. One valid strobe comes in with the operands, and one valid flag goes out with the product.

The product is built from eight AND-gated partial-product rows. Each row is shifted by its index, and a combinational adder array sums all the rows in one cycle. In signed mode, selected row bits are inverted and two fixed ones are added to the sum. This yields the two's-complement product without sign-extending any row and without subtracting the sign row. A single output register captures the result only when the strobe is high. It holds the last result otherwise. The block has no state machine: its only state is the output register and the valid flag.

Top module: `bw_mult`

## Requirements
- R1: With `signed_mode` = 0, `product` equals the unsigned product of `a_in` and `b_in`. This holds across the full range, for example 255 × 255 = 16'hFE01.
- R2: With `signed_mode` = 1, `product` equals the two's-complement product of `a_in` and `b_in`, taken modulo 2^16. This includes -128 × -128 = 16'h4000 and -128 × 127 = 16'hC080.
- R3: In signed mode, mixed-sign and all-ones operands give the correct results: -1 × -1 = 16'h0001, -3 × 5 = 16'hFFF1, and 7 × -2 = 16'hFFF2.
- R4: The mode applies per transaction. The same operand bits 8'hFF and 8'h80 give 16'h7F80 in unsigned mode and 16'h0080 in signed mode, on consecutive cycles.
- R5: `out_valid` is 1 in the cycle after a cycle with `in_valid` = 1. It is 0 in the cycle after a cycle with `in_valid` = 0.
- R6: A new operand pair is accepted on every clock. Back-to-back strobes give one result per cycle, each one cycle late.
- R7: When `in_valid` = 0, `product` keeps its previous value, whatever happens on `a_in`, `b_in` and `signed_mode`.
- R8: A synchronous active-high `rst` sets `product` to 0 and `out_valid` to 0 at the next edge. It does this even when `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 8 | Multiplicand |
| b_in | input | 8 | Multiplier |
| signed_mode | input | 1 | 0 = unsigned operands, 1 = two's-complement operands |
| in_valid | input | 1 | Operand strobe |
| product | output | 16 | Registered 16-bit product |
| out_valid | output | 1 | High one cycle after an accepted strobe |

## Verification
The only internal state is the output register, so any fault in it appears at the ports one cycle after the strobe.

A wrong inversion pattern or a misplaced correction one would not corrupt unsigned products. Instead, it shifts signed results by a power of two, or by a sum of row terms. This is why the vector table covers both signs of each operand and the extreme value -128.

A register that loads without the strobe would show a changed product in the first idle cycle. A valid flag that does not follow the strobe would show on the very next edge.

// File: rtl/bw_mult_pkg.sv
package bw_mult_pkg;
    localparam int OP_W   = 8;
    localparam int PROD_W = 2 * OP_W;

    typedef enum logic {
        MODE_UNSIGNED = 1'b0,
        MODE_SIGNED   = 1'b1
    } mult_mode_e;
endpackage

// File: rtl/bw_pp_rows.sv
// Builds the AND-gated partial-product rows, with signed-mode inversions.
module bw_pp_rows #(
    parameter int W = 8
) (
    input  logic [W-1:0]         mcand,
    input  logic [W-1:0]         mplier,
    input  logic                 sgn,
    output logic [W-1:0][W-1:0]  rows
);
    for (genvar r = 0; r < W; r++) begin : g_row
        for (genvar c = 0; c < W; c++) begin : g_col
            logic raw_bit;
            assign raw_bit = mcand[c] & mplier[r];
            if ((r < W - 1) && (c == W - 1)) begin : g_top_inv
                // top bit of each ordinary row replaces its sign extension
                assign rows[r][c] = raw_bit ^ sgn;
            end else if ((r == W - 1) && (c < W - 1)) begin : g_sign_row_inv
                // sign row: lower bits inverted turns subtraction into addition
                assign rows[r][c] = raw_bit ^ sgn;
            end else begin : g_plain
                assign rows[r][c] = raw_bit;
            end
        end
    end
endmodule

// File: rtl/bw_adder_array.sv
// Sums all shifted rows plus the correction constant in one combinational pass.
module bw_adder_array #(
    parameter int W = 8
) (
    input  logic [W-1:0][W-1:0] rows,
    input  logic                sgn,
    output logic [2*W-1:0]      sum
);
    localparam int PW = 2 * W;

    logic [PW-1:0] corr;
    logic [PW-1:0] acc [W+1];

    always_comb begin
        corr         = '0;
        corr[W]      = sgn;
        corr[PW-1]   = sgn;
    end

    assign acc[0] = corr;

    for (genvar r = 0; r < W; r++) begin : g_stage
        logic [PW-1:0] shifted;
        assign shifted    = {{W{1'b0}}, rows[r]} << r;
        assign acc[r + 1] = acc[r] + shifted;   // carry out of the top bit dropped
    end

    assign sum = acc[W];
endmodule

// File: rtl/bw_mult.sv
module bw_mult
    import bw_mult_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   a_in,
    input  logic [OP_W-1:0]   b_in,
    input  logic              signed_mode,
    input  logic              in_valid,
    output logic [PROD_W-1:0] product,
    output logic              out_valid
);
    mult_mode_e                 mode_q;
    logic                       sgn;
    logic [OP_W-1:0][OP_W-1:0]  pp_rows;
    logic [PROD_W-1:0]          pp_sum;

    assign mode_q = mult_mode_e'(signed_mode);
    assign sgn    = (mode_q == MODE_SIGNED);

    bw_pp_rows #(.W(OP_W)) u_rows (
        .mcand  (a_in),
        .mplier (b_in),
        .sgn    (sgn),
        .rows   (pp_rows)
    );

    bw_adder_array #(.W(OP_W)) u_sum (
        .rows (pp_rows),
        .sgn  (sgn),
        .sum  (pp_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            product   <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                product <= pp_sum;
            end
        end
    end
endmodule

// File: rtl/bw_mult_chk.sv
module bw_mult_chk
    import bw_mult_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [OP_W-1:0]   a_in,
    input logic [OP_W-1:0]   b_in,
    input logic              signed_mode,
    input logic              in_valid,
    input logic [PROD_W-1:0] product,
    input logic              out_valid
);
    logic [PROD_W-1:0] ref_u;
    logic [PROD_W-1:0] ref_s;

    assign ref_u = PROD_W'(a_in) * PROD_W'(b_in);
    assign ref_s = PROD_W'($signed(a_in) * $signed(b_in));

    AST_UNSIGNED_PRODUCT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !signed_mode) |=> (product == $past(ref_u)));           // R1
    AST_SIGNED_PRODUCT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && signed_mode) |=> (product == $past(ref_s)));            // R2
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);                                             // R5
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);                                           // R5
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(product));                                     // R7
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (product == '0 && !out_valid));                       // R8
endmodule

bind bw_mult bw_mult_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .a_in        (a_in),
    .b_in        (b_in),
    .signed_mode (signed_mode),
    .in_valid    (in_valid),
    .product     (product),
    .out_valid   (out_valid)
);

// File: tb/bw_mult_test.sv
module bw_mult_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  a_in = '0;
    logic [7:0]  b_in = '0;
    logic        signed_mode = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] product;
    logic        out_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    bw_mult uut (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .signed_mode(signed_mode), .in_valid(in_valid),
        .product(product), .out_valid(out_valid)
    );

    // {mode, a, b, expected}
    localparam int NV = 14;
    localparam logic [32:0] VEC [NV] = '{
        {1'b0, 8'h03, 8'h05, 16'h000F},   // R1
        {1'b0, 8'hFF, 8'hFF, 16'hFE01},   // R1
        {1'b0, 8'h80, 8'h02, 16'h0100},   // R1
        {1'b0, 8'h00, 8'hC8, 16'h0000},   // R1
        {1'b0, 8'hAA, 8'h55, 16'h3872},   // R1
        {1'b1, 8'h80, 8'h80, 16'h4000},   // R2
        {1'b1, 8'h80, 8'h7F, 16'hC080},   // R2
        {1'b1, 8'h7F, 8'h7F, 16'h3F01},   // R2
        {1'b1, 8'h00, 8'h80, 16'h0000},   // R2
        {1'b1, 8'hFF, 8'hFF, 16'h0001},   // R3
        {1'b1, 8'hFD, 8'h05, 16'hFFF1},   // R3
        {1'b1, 8'h07, 8'hFE, 16'hFFF2},   // R3
        {1'b0, 8'hFF, 8'h80, 16'h7F80},   // R4
        {1'b1, 8'hFF, 8'h80, 16'h0080}    // R4
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] last;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R8 reset product", product, 16'h0000);
        check("R8 reset valid", {15'b0, out_valid}, 16'h0001 & 16'h0000);

        // back-to-back table walk: one result every cycle
        for (int k = 0; k < NV; k++) begin
            signed_mode = VEC[k][32];
            a_in        = VEC[k][31:24];
            b_in        = VEC[k][23:16];
            in_valid    = 1'b1;
            @(negedge clk);
            check(k < 5 ? "R1" : (k < 9 ? "R2" : (k < 12 ? "R3" : "R4")),
                  product, VEC[k][15:0]);
            check("R6 valid per cycle", {15'b0, out_valid}, 16'h0001);
        end

        // idle: inputs change, product holds, valid drops
        last        = product;
        in_valid    = 1'b0;
        a_in        = 8'h12;
        b_in        = 8'h34;
        signed_mode = 1'b0;
        @(negedge clk);
        check("R7 hold", product, last);
        check("R5 valid low", {15'b0, out_valid}, 16'h0000);
        a_in = 8'h99;
        signed_mode = 1'b1;
        @(negedge clk);
        check("R7 hold second idle", product, last);

        // single strobe then idle
        a_in = 8'h10; b_in = 8'h10; signed_mode = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        check("R5 valid after strobe", {15'b0, out_valid}, 16'h0001);
        check("R1 single", product, 16'h0100);
        in_valid = 1'b0;
        @(negedge clk);
        check("R5 valid cleared", {15'b0, out_valid}, 16'h0000);

        // reset wins over strobe
        a_in = 8'h7F; b_in = 8'h7F; in_valid = 1'b1; rst = 1'b1;
        @(negedge clk);
        check("R8 reset product with strobe", product, 16'h0000);
        check("R8 reset valid with strobe", {15'b0, out_valid}, 16'h0000);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", product, 16'h3F01);
        in_valid = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule